// File: doc/BRIEF.md
# Programming Pulse Sequencer for a Multiplexed-Bus OTP Memory

This controller produces the complete programming waveform for a one-time-programmable memory whose low address byte and data byte share one 8-bit bus, with a ninth address line on a separate pin. A host issues one request. The request carries a 9-bit address and an 8-bit byte, plus a flag that selects a program cycle or an identification read.

For a program cycle, the controller does the following in order:
- It places the address on the bus and latches it with a strobe.
- It swaps the bus to the data byte and raises a request to an external high-voltage switch on the shared output-enable/programming-voltage pin.
- It reuses the same strobe as the timed programming pulse.
- It backs off the high voltage, releases the bus, and reads the location back to compare it with the requested byte.

An identification read latches the address and raises a request for the identification voltage. It then reads the byte and compares it with the fixed manufacturer code (0x1E, address line 8 low) or device code (0x9D, address line 8 high). The analog supplies are outside the block; it only issues enable requests.

Every interval is a cycle count computed at elaboration as ceil(time × `CLK_HZ`). Elaboration stops with an error if the programming pulse count cannot land inside its tolerance window.

The states and transitions are as follows:
- IDLE goes to ADDR when a request is accepted.
- The address phase runs ADDR → ALE → AHOLD.
- For a program cycle, AHOLD goes to GAP, then VPPSET → PULSE → HOLD → RECOV.
- For an identification read, AHOLD goes directly to RECOV.
- Both paths continue RECOV → READ → FLOAT → IDLE.
- Every transition out of a non-idle state happens when its interval timer expires.

Top module: `prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ale`, `vpp_req`, `bus_oe` and `id_hv_req` are 0 and `oe_n` is 1.
- R2: In the address phase, `{addr_hi, bus_out}` equals the requested address. The bus holds this value at least 100 ns before `ale` falls and at least 100 ns after it falls. `ale` is high for at least 500 ns.
- R3: `vpp_req` rises at least 2 µs after the address strobe falls. `vpp_req` is high, and the data byte is steady on `bus_out`, for at least 2 µs before the programming pulse on `ale` rises.
- R4: Each program cycle gives exactly one `ale` pulse while `vpp_req` is high. That pulse lasts between 47.5 µs and 52.5 µs, and `vpp_req` does not change while `ale` is high.
- R5: After the programming pulse, the data byte stays driven for at least 2 µs and `vpp_req` stays high for at least 2 µs. `vpp_req` has then been low for at least 2 µs before `oe_n` falls.
- R6: `bus_oe` is 0 in at least the cycle before `oe_n` falls, and while `oe_n` is low. It rises again only 130 ns or more after `oe_n` rises. `oe_n` low and `vpp_req` high never occur together.
- R7: The verify byte is sampled on the last cycle of a 150 ns `oe_n` low window. It appears on `rd_data`. `fail` is 1 exactly when any bit differs from the requested byte. There is no retry.
- R8: An identification read holds `id_hv_req` high while busy. It gives no `vpp_req` and no programming pulse. It reports `fail` = 0 only when the byte read is 0x1E for address line 8 low or 0x9D for address line 8 high.
- R9: `busy` is high from the cycle after acceptance until the result is posted. `done` is a one-cycle pulse in the first cycle with `busy` low, and `rd_data`/`fail` are valid from then on. A request while busy has no effect on the address, data or kind of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_id | input | 1 | 1 = identification read, 0 = program cycle |
| req_addr | input | 9 | Target address; bit 8 goes to `addr_hi` |
| req_data | input | 8 | Byte to program |
| bus_in | input | 8 | Bus value read from the memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Verify or identification mismatch |
| rd_data | output | 8 | Byte read in the last read phase |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus drive enable |
| addr_hi | output | 1 | Address line 8 |
| ale | output | 1 | Address strobe and programming pulse |
| oe_n | output | 1 | Active-low read enable on the shared pin |
| vpp_req | output | 1 | Request for programming voltage on the shared pin |
| id_hv_req | output | 1 | Request for identification voltage |

## Verification
Several rules are checked by assertions on every cycle:
- the mutual exclusion of read enable and programming voltage;
- bus release around the read enable;
- a steady voltage request while the strobe is high;
- one-cycle `done`;
- the timer's down-count;
- ignored requests not disturbing the latched operation.

The interval lengths themselves, the pulse count per cycle, the compare outcome and the identification codes only show up through the bench's scenarios. The bench sweeps addresses over both halves of the array with varied data. It sends reprogramming attempts that cannot clear bits, identification reads at both locations, and a corrupted identification response, and it measures each timing window against a memory model.

// File: rtl/prog_pkg.sv
package prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ALE,
        ST_AHOLD,
        ST_GAP,
        ST_VPPSET,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV,
        ST_READ,
        ST_FLOAT
    } prog_state_e;

    localparam logic [7:0] MFR_CODE = 8'h1E;
    localparam logic [7:0] DEV_CODE = 8'h9D;

    // ceil(ns * hz / 1e9)
    function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned prod;
        prod = ns * hz + 64'd999_999_999;
        return 32'(prod / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4: every timed window counts down one step per cycle
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prog_check.sv
module prog_check
    import prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       post,
    input  logic       is_id,
    input  logic       addr8,
    input  logic [7:0] want,
    input  logic [7:0] bus_in,
    output logic [7:0] rd_data,
    output logic       fail,
    output logic       done
);
    logic [7:0] ref_byte;

    always_comb begin
        if (is_id) ref_byte = addr8 ? DEV_CODE : MFR_CODE;
        else       ref_byte = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            fail    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= post;
            if (sample) begin
                rd_data <= bus_in;
                fail    <= (bus_in != ref_byte);
            end
        end
    end

    // R9: the result strobe lasts a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the posted result does not move between samples
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sample) && $past(rst_n)) |-> ($stable(rd_data) && $stable(fail)));

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_id,
    input  logic [8:0] req_addr,
    input  logic [7:0] req_data,
    input  logic [7:0] bus_in,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic [7:0] rd_data,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       addr_hi,
    output logic       ale,
    output logic       oe_n,
    output logic       vpp_req,
    output logic       id_hv_req
);
    localparam int unsigned C_AS   = ns2cyc(100,   CLK_HZ);
    localparam int unsigned C_ALE  = ns2cyc(500,   CLK_HZ);
    localparam int unsigned C_AH   = ns2cyc(100,   CLK_HZ);
    localparam int unsigned C_GAP  = ns2cyc(2000,  CLK_HZ);
    localparam int unsigned C_VSET = ns2cyc(2000,  CLK_HZ);
    localparam int unsigned C_PW   = ns2cyc(50000, CLK_HZ);
    localparam int unsigned C_HOLD = ns2cyc(2000,  CLK_HZ);
    localparam int unsigned C_REC  = ns2cyc(2000,  CLK_HZ);
    localparam int unsigned C_RD   = ns2cyc(150,   CLK_HZ);
    localparam int unsigned C_FLT  = ns2cyc(130,   CLK_HZ);
    localparam int          CW     = $clog2(C_PW + 1);

    // pulse must sit inside 47.5 us .. 52.5 us
    localparam bit PW_OK = (longint'(C_PW) * 64'd1_000_000_000 >= 64'd47_500 * CLK_HZ)
                        && (longint'(C_PW) * 64'd1_000_000_000 <= 64'd52_500 * CLK_HZ);
    generate
        if (!PW_OK) begin : g_bad_clock
            $error("prog_seq: CLK_HZ gives a pulse count outside the tolerance window");
        end
    endgenerate

    prog_state_e state_q, state_d;
    logic        accept, load, tmr_done;
    logic [CW-1:0] load_val;
    logic [8:0]  addr_q;
    logic [7:0]  data_q;
    logic        id_q;

    function automatic int unsigned dur_of(prog_state_e s);
        unique case (s)
            ST_ADDR:   return C_AS;
            ST_ALE:    return C_ALE;
            ST_AHOLD:  return C_AH;
            ST_GAP:    return C_GAP;
            ST_VPPSET: return C_VSET;
            ST_PULSE:  return C_PW;
            ST_HOLD:   return C_HOLD;
            ST_RECOV:  return C_REC;
            ST_READ:   return C_RD;
            ST_FLOAT:  return C_FLT;
            default:   return 1;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (req_valid) begin state_d = ST_ADDR; accept = 1'b1; end
            ST_ADDR:   if (tmr_done) state_d = ST_ALE;
            ST_ALE:    if (tmr_done) state_d = ST_AHOLD;
            ST_AHOLD:  if (tmr_done) state_d = id_q ? ST_RECOV : ST_GAP;
            ST_GAP:    if (tmr_done) state_d = ST_VPPSET;
            ST_VPPSET: if (tmr_done) state_d = ST_PULSE;
            ST_PULSE:  if (tmr_done) state_d = ST_HOLD;
            ST_HOLD:   if (tmr_done) state_d = ST_RECOV;
            ST_RECOV:  if (tmr_done) state_d = ST_READ;
            ST_READ:   if (tmr_done) state_d = ST_FLOAT;
            ST_FLOAT:  if (tmr_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        load     = (state_d != state_q);
        load_val = CW'(dur_of(state_d) - 1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            id_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            id_q   <= req_id;
        end
    end

    // outputs
    always_comb begin
        bus_oe  = 1'b0;
        ale     = 1'b0;
        vpp_req = 1'b0;
        oe_n    = 1'b1;
        unique case (state_q)
            ST_ADDR, ST_AHOLD, ST_GAP:  bus_oe = 1'b1;
            ST_ALE:                     begin bus_oe = 1'b1; ale = 1'b1; end
            ST_VPPSET, ST_HOLD:         begin bus_oe = 1'b1; vpp_req = 1'b1; end
            ST_PULSE:                   begin bus_oe = 1'b1; vpp_req = 1'b1; ale = 1'b1; end
            ST_READ:                    oe_n = 1'b0;
            default:                    ;
        endcase
        if (!bus_oe)
            bus_out = '0;
        else if (state_q inside {ST_ADDR, ST_ALE, ST_AHOLD})
            bus_out = addr_q[7:0];
        else
            bus_out = data_q;
        busy      = (state_q != ST_IDLE);
        id_hv_req = busy && id_q;
        addr_hi   = addr_q[8];
    end

    prog_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (tmr_done)
    );

    prog_check u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (state_q == ST_READ && tmr_done),
        .post    (state_q == ST_FLOAT && tmr_done),
        .is_id   (id_q),
        .addr8   (addr_q[8]),
        .want    (data_q),
        .bus_in  (bus_in),
        .rd_data (rd_data),
        .fail    (fail),
        .done    (done)
    );

    // R6: read enable and programming voltage never overlap
    assert_oe_vpp_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(vpp_req && !oe_n));

    // R6: bus already released in the cycle before the read enable falls
    assert_bus_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(!bus_oe));

    // R4: voltage request steady while the strobe is high
    assert_vpp_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |-> $stable(vpp_req));

    // R9: requests while busy leave the captured operation alone
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q) && $stable(id_q)));

    // R9: result strobe only once the block is idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
    localparam int LAS_C = 100 / 10;
    localparam int ALE_C = 500 / 10;
    localparam int LAH_C = 100 / 10;
    localparam int LP_C  = 2000 / 10;
    localparam int OES_C = 2000 / 10;
    localparam int DS_C  = 2000 / 10;
    localparam int PWMIN = 47500 / 10;
    localparam int PWMAX = 52500 / 10;
    localparam int DH_C  = 2000 / 10;
    localparam int OEH_C = 2000 / 10;
    localparam int VR_C  = 2000 / 10;
    localparam int OE_C  = 150 / 10;
    localparam int DFP_C = 130 / 10;
    localparam int BIG   = 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_id = 1'b0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic [7:0] bus_in = '0;
    logic busy, done, fail, bus_oe, addr_hi, ale, oe_n, vpp_req, id_hv_req;
    logic [7:0] rd_data, bus_out;

    always #5 clk = ~clk;

    prog_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_addr(req_addr), .req_data(req_data), .bus_in(bus_in),
        .busy(busy), .done(done), .fail(fail), .rd_data(rd_data),
        .bus_out(bus_out), .bus_oe(bus_oe), .addr_hi(addr_hi), .ale(ale),
        .oe_n(oe_n), .vpp_req(vpp_req), .id_hv_req(id_hv_req)
    );

    int tests = 0, fails = 0, cyc = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190_000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // memory model: erased = FF, programming only clears bits
    logic [7:0] mem [512];
    logic [7:0] shadow [512];
    logic [8:0] lat = '0, pulse_addr = '0;
    logic m_prev_ale = 1'b0;
    int oe_cnt = 0;
    bit bad_id = 1'b0;
    logic [7:0] rd_val;

    always_comb begin
        if (id_hv_req) rd_val = (lat[8] ? 8'h9D : 8'h1E) ^ {7'b0, bad_id};
        else           rd_val = mem[lat];
    end

    always @(negedge clk) begin
        m_prev_ale <= ale;
        if (m_prev_ale && !ale) begin
            if (vpp_req) begin
                mem[lat]   <= mem[lat] & bus_out;
                pulse_addr <= lat;
            end else begin
                lat <= {addr_hi, bus_out};
            end
        end
        if (!oe_n) begin
            oe_cnt <= oe_cnt + 1;
            bus_in <= (oe_cnt + 1 >= OE_C) ? rd_val : ~rd_val;
        end else begin
            oe_cnt <= 0;
            bus_in <= 8'h00;
        end
    end

    // waveform monitor
    logic p_ale = 0, p_vpp = 0, p_oen = 1, p_boe = 0;
    logic [7:0] p_bus = 0;
    int ale_hi = 0, vpp_hi = 0, bus_st = 0, bus_off = 0;
    int since_latch = BIG, since_pulse = BIG, since_vfall = BIG, since_oerise = BIG;
    bit latch_pend = 0, pulse_pend = 0, overlap = 0;
    int pulses = 0, vpp_rises = 0;
    logic [8:0] latched_seen = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ale && !ale) begin
                if (p_vpp) begin
                    chk(ale_hi >= PWMIN && ale_hi <= PWMAX, "R4 pulse width", ale_hi, 5000);
                    pulses++;
                    since_pulse = 0;
                    pulse_pend = 1;
                end else begin
                    chk(ale_hi >= ALE_C, "R2 latch strobe width", ale_hi, ALE_C);
                    chk(bus_st >= LAS_C, "R2 address setup", bus_st, LAS_C);
                    latched_seen = {addr_hi, bus_out};
                    since_latch = 0;
                    latch_pend = 1;
                end
            end
            if (!p_ale && ale && vpp_req) begin
                chk(vpp_hi >= OES_C, "R3 vpp setup", vpp_hi, OES_C);
                chk(bus_st >= DS_C, "R3 data setup", bus_st, DS_C);
            end
            if (!p_vpp && vpp_req) begin
                vpp_rises++;
                chk(since_latch >= LP_C, "R3 strobe low to vpp", since_latch, LP_C);
            end
            if (p_vpp && !vpp_req) begin
                chk(since_pulse >= OEH_C, "R5 vpp hold", since_pulse, OEH_C);
                since_vfall = 0;
            end
            if ((bus_out != p_bus || bus_oe != p_boe) && latch_pend) begin
                chk(since_latch >= LAH_C, "R2 address hold", since_latch, LAH_C);
                latch_pend = 0;
            end
            if (p_boe && !bus_oe && pulse_pend) begin
                chk(since_pulse >= DH_C, "R5 data hold", since_pulse, DH_C);
                pulse_pend = 0;
            end
            if (p_oen && !oe_n) begin
                chk(since_vfall >= VR_C, "R5 recovery", since_vfall, VR_C);
                chk(bus_off >= 1, "R6 bus released before read", bus_off, 1);
            end
            if (!p_oen && oe_n) since_oerise = 0;
            if (!p_boe && bus_oe)
                chk(since_oerise >= DFP_C, "R6 float before redrive", since_oerise, DFP_C);
            if (!oe_n && (vpp_req || bus_oe)) overlap = 1;

            ale_hi  = ale ? ale_hi + 1 : 0;
            vpp_hi  = vpp_req ? vpp_hi + 1 : 0;
            bus_off = bus_oe ? 0 : bus_off + 1;
            bus_st  = (bus_out != p_bus || bus_oe != p_boe) ? 1 : bus_st + 1;
            if (since_latch  < BIG) since_latch++;
            if (since_pulse  < BIG) since_pulse++;
            if (since_vfall  < BIG) since_vfall++;
            if (since_oerise < BIG) since_oerise++;
        end
        p_ale = ale; p_vpp = vpp_req; p_oen = oe_n; p_boe = bus_oe; p_bus = bus_out;
    end

    task automatic run_op(input bit id, input logic [8:0] a, input logic [7:0] d,
                          input int intrude_at, output logic [7:0] rdv,
                          output bit fl, output int np, output int nv);
        int p0, v0;
        p0 = pulses; v0 = vpp_rises;
        @(negedge clk);
        req_valid = 1; req_id = id; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        if (id) chk(id_hv_req == 1'b1, "R8 id voltage request", id_hv_req, 1);
        if (intrude_at > 0) begin
            repeat (intrude_at) @(negedge clk);
            req_valid = 1; req_id = !id; req_addr = ~a; req_data = ~d;
            @(negedge clk);
            req_valid = 0;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        rdv = rd_data; fl = fail;
        np = pulses - p0; nv = vpp_rises - v0;
        chk(latched_seen == a, "R2 latched address", int'(latched_seen), int'(a));
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    initial begin
        logic [7:0] rdv, expv;
        bit fl;
        int np, nv;
        for (int k = 0; k < 512; k++) begin mem[k] = 8'hFF; shadow[k] = 8'hFF; end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ale && !vpp_req && !bus_oe && !id_hv_req && oe_n,
            "R1 reset outputs", {busy, done, ale, vpp_req, bus_oe, id_hv_req, oe_n}, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy && oe_n && !vpp_req, "R1 idle after reset", busy, 0);

        // sweep of program cycles over both halves of the array
        for (int i = 0; i < 12; i++) begin
            logic [8:0] a;
            logic [7:0] d;
            a = {i[0], 8'(i * 37 + 5)};
            d = 8'(i * 91 + 3);
            run_op(0, a, d, (i == 3) ? 400 : 0, rdv, fl, np, nv);
            expv = shadow[a] & d;
            shadow[a] = expv;
            chk(np == 1, "R4 one pulse per cycle", np, 1);
            chk(int'(pulse_addr) == int'(a), "R9 programmed address", int'(pulse_addr), int'(a));
            chk(rdv == expv, "R7 verify byte", rdv, expv);
            chk(fl == (expv != d), "R7 verify flag", fl, int'(expv != d));
            if (i == 3)
                chk(mem[~a] == shadow[~a], "R9 busy request ignored", mem[~a], shadow[~a]);
        end

        // rewrite needing a cleared bit to rise: must fail
        run_op(0, {1'b0, 8'd5}, 8'hFF, 0, rdv, fl, np, nv);
        expv = shadow[9'd5];
        chk(rdv == expv, "R7 readback after bad rewrite", rdv, expv);
        chk(fl == 1'b1, "R7 mismatch flagged", fl, 1);
        // rewrite clearing more bits only: must pass
        run_op(0, {1'b0, 8'd5}, expv & 8'h0F, 0, rdv, fl, np, nv);
        chk(rdv == (expv & 8'h0F), "R7 readback subset", rdv, expv & 8'h0F);
        chk(fl == 1'b0, "R7 subset passes", fl, 0);

        // identification reads
        run_op(1, 9'h000, 8'h00, 0, rdv, fl, np, nv);
        chk(rdv == 8'h1E && !fl, "R8 manufacturer code", rdv, 8'h1E);
        chk(np == 0 && nv == 0, "R8 no programming in id read", np + nv, 0);
        run_op(1, 9'h101, 8'h00, 60, rdv, fl, np, nv);
        chk(rdv == 8'h9D && !fl, "R8 device code", rdv, 8'h9D);
        chk(np == 0 && nv == 0, "R9 ignored request during id read", np + nv, 0);
        bad_id = 1;
        run_op(1, 9'h100, 8'h00, 0, rdv, fl, np, nv);
        chk(rdv == 8'h9C && fl, "R8 wrong code flagged", fl, 1);
        bad_id = 0;

        chk(!overlap, "R6 read enable overlap", overlap, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule